// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port controlled through a small word-addressed register interface with separate read and write strobes. Software sets an output latch and a per-pin direction, and reads back the pin levels after they pass a two-flop synchroniser. Each pin can also raise an interrupt.

Each pin has a 2-bit trigger code. It selects a low level, a high level, a rising edge or a falling edge. A separate per-pin register overrides the code so that the pin triggers on any transition. Detected events are held in a status register that software clears by writing ones. The status is gated by a mask register. The port drives one request line for the lower half of the pins, one for the upper half, and a combined line.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the output latch, direction, both trigger config words, mask, status and any-edge select all read zero, every pin is an input (pin_oe = 0), and all three interrupt outputs are low.
- R2: Offset 0x00 holds the output latch, which drives pin_out. Offset 0x04 holds direction, where 1 makes a pin an output (pin_oe = 1). Reading 0x00 returns the latch value, not the pin level.
- R3: Offset 0x08 returns the pin levels through a two-flop synchroniser: a change at pin_in is readable after the second rising clock edge and not after the first. Writes to 0x08 change nothing.
- R4: Pins 0 to 15 take their trigger code from offset 0x0C and pins 16 to 31 from offset 0x10. Pin n uses bits [2k+1:2k] of that word, with k = n mod 16.
- R5: The trigger codes are 00 = low level, 01 = high level, 10 = rising edge, 11 = falling edge. An edge is found by comparing the synchronised level with its value one cycle earlier. The status bit is readable after the third rising clock edge following the pin change, and a transition of the other direction sets nothing.
- R6: A 1 in a pin's bit of the any-edge select word at offset 0x1C makes that pin trigger on both rising and falling transitions, whatever its trigger code says.
- R7: Status at offset 0x18 holds detected events until cleared. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R8: In level mode the status bit is set on every cycle that the level matches. When a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R9: Mask is at offset 0x14. irq_lo is high when any pin 0 to 15 has both its status and mask bits set, irq_hi does the same for pins 16 to 31, and irq_any is their OR. Masking does not alter the status readback.
- R10: Reads of any offset other than the eight mapped ones return zero, and rdata is zero while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |
| pin_in | input | 32 | Levels sensed at the pads |
| pin_out | output | 32 | Output latch driven toward the pads |
| pin_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Pending request from pins 0 to 15 |
| irq_hi | output | 1 | Pending request from pins 16 to 31 |
| irq_any | output | 1 | OR of the two half requests |

## Verification
The bench targets a clear that collides with a persisting level. A design that let the clear win would read the bit as zero right after the write. It checks that the trigger code is taken from the right word and bit pair for pins in each half. A swapped pair or half would fire on the wrong edge or on no edge at all. It also checks that the any-edge select overrides a falling-edge code, so a design that still honoured the code would miss the rising transition. Further checks confirm that reads of the output latch ignore the pin level, that the sync delay is exactly two edges, and that the two request lines are split by half.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq_lo,
  output logic            irq_hi,
  output logic            irq_any
);
  localparam int HALF = NPIN / 2;

  localparam logic [AW-1:0] OFS_OUT  = AW'(8'h00);
  localparam logic [AW-1:0] OFS_DIR  = AW'(8'h04);
  localparam logic [AW-1:0] OFS_PAD  = AW'(8'h08);
  localparam logic [AW-1:0] OFS_TLO  = AW'(8'h0C);
  localparam logic [AW-1:0] OFS_THI  = AW'(8'h10);
  localparam logic [AW-1:0] OFS_MASK = AW'(8'h14);
  localparam logic [AW-1:0] OFS_STAT = AW'(8'h18);
  localparam logic [AW-1:0] OFS_ANY  = AW'(8'h1C);

  logic [NPIN-1:0] out_q, dir_q, tlo_q, thi_q, mask_q, status_q, any_q;
  logic [NPIN-1:0] sync1_q, sync2_q, prev_q;
  logic [NPIN-1:0] evt, clr, pend;

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    localparam int K = n % HALF;
    logic [1:0] code;
    logic       hit;
    if (n < HALF) begin : g_lo
      assign code = tlo_q[2*K+1 -: 2];
    end else begin : g_hi
      assign code = thi_q[2*K+1 -: 2];
    end
    always_comb begin
      if (any_q[n]) hit = sync2_q[n] ^ prev_q[n];
      else begin
        case (code)
          2'b00:   hit = ~sync2_q[n];
          2'b01:   hit = sync2_q[n];
          2'b10:   hit = sync2_q[n] & ~prev_q[n];
          default: hit = ~sync2_q[n] & prev_q[n];
        endcase
      end
    end
    assign evt[n] = hit;
  end

  assign clr = (wr_en && addr == OFS_STAT) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      dir_q    <= '0;
      tlo_q    <= '0;
      thi_q    <= '0;
      mask_q   <= '0;
      status_q <= '0;
      any_q    <= '0;
      sync1_q  <= '0;
      sync2_q  <= '0;
      prev_q   <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          OFS_OUT:  out_q  <= wdata;
          OFS_DIR:  dir_q  <= wdata;
          OFS_TLO:  tlo_q  <= wdata;
          OFS_THI:  thi_q  <= wdata;
          OFS_MASK: mask_q <= wdata;
          OFS_ANY:  any_q  <= wdata;
          default: ;
        endcase
      end
      status_q <= (status_q & ~clr) | evt;
      sync1_q  <= pin_in;
      sync2_q  <= sync1_q;
      prev_q   <= sync2_q;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_OUT:  rdata = out_q;
        OFS_DIR:  rdata = dir_q;
        OFS_PAD:  rdata = sync2_q;
        OFS_TLO:  rdata = tlo_q;
        OFS_THI:  rdata = thi_q;
        OFS_MASK: rdata = mask_q;
        OFS_STAT: rdata = status_q;
        OFS_ANY:  rdata = any_q;
        default:  rdata = '0;
      endcase
    end
  end

  assign pend    = status_q & mask_q;
  assign irq_lo  = |pend[HALF-1:0];
  assign irq_hi  = |pend[NPIN-1:HALF];
  assign irq_any = irq_lo | irq_hi;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [NPIN-1:0] wdata,
  input logic [NPIN-1:0] status,
  input logic [NPIN-1:0] evt,
  input logic [NPIN-1:0] mask,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq_any
);
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  AST_SET_ONLY_BY_EVENT: assert property (@(posedge clk) disable iff (!rst_n || !live)
    ((status & ~$past(status) & ~$past(evt)) == '0)); // R5
  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $past(wr_en && addr == AW'(8'h18)) |-> ((status & $past(wdata) & ~$past(evt)) == '0)); // R7
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (($past(evt) & ~status) == '0)); // R8
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_any); // R9
  AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $past(wr_en && addr == AW'(8'h04)) |-> (pin_oe == $past(wdata))); // R2
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .status(status_q), .evt(evt), .mask(mask_q), .pin_oe(pin_oe), .irq_any(irq_any)
);

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
  logic        irq_lo, irq_hi, irq_any;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
  );

  localparam logic [7:0] OUT = 8'h00, DIR = 8'h04, PAD = 8'h08, TLO = 8'h0C,
                         THI = 8'h10, MSK = 8'h14, STA = 8'h18, ANY = 8'h1C;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a; #1; d = rdata; rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pin(int n, bit v);
    @(negedge clk); pin_in[n] = v;
    settle();
  endtask

  task automatic expect_reg(string req, string what, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, what, d, exp);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    rd(STA, d); chk("R1", "status in reset", d, 32'h0);
    rd(MSK, d); chk("R1", "mask in reset", d, 32'h0);
    rd(DIR, d); chk("R1", "dir in reset", d, 32'h0);
    rd(OUT, d); chk("R1", "out in reset", d, 32'h0);
    chk("R1", "pin_oe in reset", pin_oe, 32'h0);
    chk("R1", "irq in reset", {29'h0, irq_lo, irq_hi, irq_any}, 32'h0);
  endtask

  task automatic t_data_dir();
    wr(OUT, 32'hA5A5_5A5A);
    wr(DIR, 32'hFFFF_0000);
    chk("R2", "pin_out follows latch", pin_out, 32'hA5A5_5A5A);
    chk("R2", "pin_oe follows dir", pin_oe, 32'hFFFF_0000);
    expect_reg("R2", "latch readback not pin", OUT, 32'hA5A5_5A5A);
  endtask

  task automatic t_pad();
    logic [31:0] d;
    @(negedge clk); pin_in = 32'h1234_5678;
    @(posedge clk); @(negedge clk);
    rd(PAD, d); chk("R3", "pad after one edge", d, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(PAD, d); chk("R3", "pad after two edges", d, 32'h1234_5678);
    wr(PAD, 32'hFFFF_FFFF);
    expect_reg("R3", "pad write ignored", PAD, 32'h1234_5678);
    expect_reg("R3", "pad write leaves latch", OUT, 32'hA5A5_5A5A);
    expect_reg("R10", "unmapped 0x20", 8'h20, 32'h0);
    expect_reg("R10", "unmapped 0x24", 8'h24, 32'h0);
    addr = OUT; #1;
    chk("R10", "rdata with rd_en low", rdata, 32'h0);
    @(negedge clk); pin_in = 32'h0;
    settle();
  endtask

  task automatic t_setup_rise();
    wr(TLO, 32'hAAAA_AAAA);
    wr(THI, 32'hAAAA_AAAA);
    wr(ANY, 32'h0);
    wr(STA, 32'hFFFF_FFFF);
    settle();
    expect_reg("R7", "status cleared by ones", STA, 32'h0);
    set_pin(3, 1);
    expect_reg("R5", "rising edge pin3", STA, 32'h0000_0008);
    wr(STA, 32'h0);
    expect_reg("R7", "zero write keeps bit", STA, 32'h0000_0008);
    wr(STA, 32'h0000_0008);
    expect_reg("R7", "one write clears bit", STA, 32'h0);
    set_pin(3, 0);
    expect_reg("R5", "falling ignored in rise mode", STA, 32'h0);
  endtask

  task automatic t_fall_hi();
    wr(THI, 32'hAAAA_ABAA);
    set_pin(20, 1);
    expect_reg("R4", "pin20 rise ignored in fall mode", STA, 32'h0);
    set_pin(20, 0);
    expect_reg("R4", "pin20 falling uses high word bits 9:8", STA, 32'h0010_0000);
    wr(STA, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    wr(TLO, 32'hAAAA_A6AA);
    set_pin(5, 1);
    expect_reg("R5", "high level pin5", STA, 32'h0000_0020);
    wr(STA, 32'h0000_0020);
    expect_reg("R8", "set wins over clear", STA, 32'h0000_0020);
    set_pin(5, 0);
    wr(STA, 32'h0000_0020);
    expect_reg("R8", "clear sticks once level gone", STA, 32'h0);
    wr(TLO, 32'hAAA2_A6AA);
    settle();
    expect_reg("R5", "low level pin9", STA, 32'h0000_0200);
    set_pin(9, 1);
    wr(STA, 32'hFFFF_FFFF);
    expect_reg("R5", "low level ends when pin high", STA, 32'h0);
    wr(TLO, 32'hAAAA_AAAA);
  endtask

  task automatic t_both();
    wr(TLO, 32'hAAAA_EAAA);
    wr(ANY, 32'h0000_0080);
    set_pin(7, 1);
    expect_reg("R6", "rise fires despite fall code", STA, 32'h0000_0080);
    wr(STA, 32'h0000_0080);
    set_pin(7, 0);
    expect_reg("R6", "fall fires with any-edge", STA, 32'h0000_0080);
    wr(STA, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq();
    set_pin(3, 1);
    chk("R9", "no irq with mask clear", {31'h0, irq_any}, 32'h0);
    wr(MSK, 32'h0000_0008);
    chk("R9", "irq_lo from pin3", {29'h0, irq_lo, irq_hi, irq_any}, 32'h5);
    set_pin(20, 1);
    set_pin(20, 0);
    wr(MSK, 32'h0010_0000);
    chk("R9", "irq_hi from pin20", {29'h0, irq_lo, irq_hi, irq_any}, 32'h3);
    expect_reg("R9", "status unaffected by mask", STA, 32'h0010_0008);
    wr(STA, 32'hFFFF_FFFF);
    chk("R9", "irq gone after clear", {29'h0, irq_lo, irq_hi, irq_any}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_data_dir();
    t_pad();
    t_setup_rise();
    t_fall_hi();
    t_level();
    t_both();
    t_irq();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule